// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Processor Status Register

This block is the datapath heart of a small accumulator-based CPU core. It takes two operands (the accumulator value on `op_a` and the memory or immediate operand on `op_b`), an operation code, and a flag-update enable. It returns the operation's result at once, through combinational logic. It also holds the processor status byte, which changes on a clock edge whenever the update enable is high. The carry input of every carry-consuming operation comes from the stored carry flag. Decoding instructions and moving data to and from memory are left to the surrounding core.

Each operation class owns a fixed subset of the flags and leaves the rest untouched:

- Comparison never alters overflow.
- Increment and decrement never alter carry or overflow.
- Bit test takes negative and overflow straight from the operand.
- Test-and-set and test-and-reset report only the zero flag.

The decimal flag is stored but has no effect. All arithmetic here is binary, and any decimal correction belongs to another block.

A status-load operation lets the core restore the complete status byte, for example after pulling it from a stack.

Top module: `alu_status_unit`

## Requirements
- R1: The status byte is laid out as N=bit7, V=bit6, constant 1 at bit5, B=bit4, D=bit3, I=bit2, Z=bit1, C=bit0. Bit 5 always reads 1, and a synchronous reset (rst_n low at a rising edge) sets the status to 0x20.
- R2: The status changes only at a rising clock edge with rst_n high and upd_en high. With upd_en low it keeps its value whatever the operation.
- R3: Op codes 0 (OR), 1 (AND), 2 (XOR) and 3 (pass `op_b`) return op_a|op_b, op_a&op_b, op_a^op_b and op_b. They set N to result bit 7 and Z to (result==0), and leave V, C and the other bits unchanged.
- R4: Op 4 (add) returns the low 8 bits of op_a+op_b+C. C becomes the carry out of bit 7, and V becomes the signed overflow (the carry into bit 7 XOR the carry out of bit 7). N and Z come from the result.
- R5: Op 5 (subtract) returns the low 8 bits of op_a-op_b-(1-C). C becomes 1 when no borrow occurs, V becomes the signed overflow, and N and Z come from the result.
- R6: Op 6 (compare) returns op_a unchanged. It sets N to bit 7 of (op_a-op_b), Z to (op_a==op_b) and C to (op_a>=op_b) unsigned, and leaves V unchanged.
- R7: Op 7 (bit test) returns op_a and sets N=op_b[7], V=op_b[6], Z=((op_a&op_b)==0). Op 8 (immediate bit test) returns op_a and updates only Z in the same way.
- R8: Ops 9 to 12 act on op_b. Op 9 is shift left (C gets bit 7, bit 0 gets 0). Op 10 is logical shift right (C gets bit 0, bit 7 gets 0). Op 11 rotates left through C, and op 12 rotates right through C. All four set N, Z and C, and leave V unchanged.
- R9: Op 13 returns op_b+1 and op 14 returns op_b-1, both modulo 256. Only N and Z are updated, and C and V stay as they were.
- R10: Op 15 (test-and-set) returns op_b|op_a and op 16 (test-and-reset) returns op_b&~op_a. Both update only Z, to ((op_a&op_b)==0).
- R11: Op 17 (status load) returns op_b and loads the whole status from op_b, with bit 5 forced to 1.
- R12: The D flag has no effect on add or subtract. The results and flags are the binary ones whether D is 0 or 1.
- R13: Op codes 18 to 31 return 0 and leave the status unchanged even with upd_en high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 5 | Operation code (see requirements) |
| op_a | input | 8 | Accumulator operand |
| op_b | input | 8 | Memory/immediate operand, also the shift, step and status-load source |
| upd_en | input | 1 | Write the operation's flag subset into the status at the next edge |
| result | output | 8 | Combinational operation result |
| status | output | 8 | Registered status byte |

## Verification
The hardest situations to reach from the ports are the ones where a flag must survive an operation that does not own it. Examples are a set V across a compare, and a set C across an increment that wraps through zero. Reaching them requires a known, arbitrary status right before the operation under test. The stimulus therefore precedes every vector with a status load that sets all eight bits to a pattern derived from the operands, with the carry swept on its own. Every flag then meets each operation both set and clear, and so does the D flag during add and subtract.

// File: rtl/alu_pkg.sv
// Shared definitions for the ALU/status unit: operation codes, status
// bit positions and the status record. Assumes an 8-bit status byte.
package alu_pkg;

    localparam int STAT_W = 8;

    // Status bit positions (fixed layout, read by neighbouring logic)
    localparam int BIT_N   = 7;
    localparam int BIT_V   = 6;
    localparam int BIT_ONE = 5;
    localparam int BIT_B   = 4;
    localparam int BIT_D   = 3;
    localparam int BIT_I   = 2;
    localparam int BIT_Z   = 1;
    localparam int BIT_C   = 0;

    localparam logic [STAT_W-1:0] STAT_RESET = 8'h20;
    localparam logic [STAT_W-1:0] STAT_FORCE = 8'h20;

    // Operation codes
    typedef enum logic [4:0] {
        OP_OR    = 5'd0,
        OP_AND   = 5'd1,
        OP_XOR   = 5'd2,
        OP_PASS  = 5'd3,
        OP_ADD   = 5'd4,
        OP_SUB   = 5'd5,
        OP_CMP   = 5'd6,
        OP_BTST  = 5'd7,
        OP_BTSTI = 5'd8,
        OP_SHL   = 5'd9,
        OP_SHR   = 5'd10,
        OP_ROTL  = 5'd11,
        OP_ROTR  = 5'd12,
        OP_INC   = 5'd13,
        OP_DEC   = 5'd14,
        OP_TSET  = 5'd15,
        OP_TCLR  = 5'd16,
        OP_SLOAD = 5'd17
    } alu_op_e;

    localparam logic [4:0] OP_LAST = 5'd17;

    // Status byte as a record, MSB first
    typedef struct packed {
        logic n;
        logic v;
        logic one;
        logic b;
        logic d;
        logic i;
        logic z;
        logic c;
    } status_t;

endpackage

// File: rtl/alu_adder.sv
// Ripple-carry adder with optional operand inversion, used for add,
// subtract and compare. Exposes the carry into and out of the top bit
// so the caller can form signed overflow. Assumes W >= 2.
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         invert_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W:0]   carry;
    logic [W-1:0] b_eff;

    // Purpose: select true or complemented second operand
    assign b_eff    = invert_b ? ~b : b;
    assign carry[0] = cin;

    for (genvar k = 0; k < W; k++) begin : g_bit
        // Purpose: one full-adder cell of the chain
        assign sum[k]     = a[k] ^ b_eff[k] ^ carry[k];
        assign carry[k+1] = (a[k] & b_eff[k]) | ((a[k] ^ b_eff[k]) & carry[k]);
    end

    assign cout = carry[W];
    // Purpose: signed overflow as carry-in XOR carry-out of the top bit
    assign ovf  = carry[W] ^ carry[W-1];

endmodule

// File: rtl/alu_unary.sv
// Single-operand unit: shifts, rotates through carry, increment and
// decrement of the memory operand. Produces the bit shifted out for
// the carry flag. Codes other than its own give zero.
module alu_unary #(
    parameter int W = 8
) (
    input  alu_pkg::alu_op_e op,
    input  logic [W-1:0]     opd,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             shout
);
    import alu_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Purpose: compute the single-operand result and the bit shifted out
    always_comb begin
        res   = '0;
        shout = 1'b0;
        unique case (op)
            OP_SHL:  begin res = {opd[W-2:0], 1'b0}; shout = opd[W-1]; end
            OP_SHR:  begin res = {1'b0, opd[W-1:1]}; shout = opd[0];   end
            OP_ROTL: begin res = {opd[W-2:0], cin};  shout = opd[W-1]; end
            OP_ROTR: begin res = {cin, opd[W-1:1]};  shout = opd[0];   end
            OP_INC:  res = opd + ONE;
            OP_DEC:  res = opd - ONE;
            default: begin res = '0; shout = 1'b0; end
        endcase
    end

endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: OR, AND, XOR, pass-through and the test-and-set /
// test-and-reset write values. Purely combinational.
module alu_logic #(
    parameter int W = 8
) (
    input  alu_pkg::alu_op_e op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     res
);
    import alu_pkg::*;

    // Purpose: select the bitwise combination for the current code
    always_comb begin
        unique case (op)
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = b;
            OP_TSET: res = b | a;
            OP_TCLR: res = b & ~a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Status register. On an enabled edge, each bit selected by the mask
// takes its new value and the others keep theirs. Bit 5 is forced to 1.
// Synchronous active-low reset.
module alu_flag_reg (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd_en,
    input  logic [alu_pkg::STAT_W-1:0]  new_val,
    input  logic [alu_pkg::STAT_W-1:0]  upd_mask,
    output logic [alu_pkg::STAT_W-1:0]  stat_q
);
    import alu_pkg::*;

    logic [STAT_W-1:0] merged;

    // Purpose: merge owned flags with retained ones, force the constant bit
    assign merged = (new_val & upd_mask) | (stat_q & ~upd_mask) | STAT_FORCE;

    // Purpose: hold or update the status byte on the clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= STAT_RESET;
        else if (upd_en)
            stat_q <= merged;
    end

endmodule

// File: rtl/alu_status_unit.sv
// Top of the ALU/status block. Selects the operation result, decides
// which flags the operation owns and their new values, and hands them
// to the status register. The data width is a parameter, but the status
// is a fixed 8-bit byte, so the status load needs W >= 8.
module alu_status_unit #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_sel,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         upd_en,
    output logic [W-1:0] result,
    output logic [7:0]   status
);
    import alu_pkg::*;

    alu_op_e      op;
    status_t      cur;
    logic [W-1:0] add_sum, logic_res, un_res;
    logic         add_cout, add_ovf, un_shout;
    logic         sub_mode, add_cin;
    logic [W-1:0] and_ab;
    status_t      fl_val, fl_mask;

    assign op  = alu_op_e'(op_sel);
    assign cur = status_t'(status);

    // Purpose: subtract and compare use the inverted operand; compare ignores C
    assign sub_mode = (op == OP_SUB) || (op == OP_CMP);
    assign add_cin  = (op == OP_CMP) ? 1'b1 : cur.c;
    assign and_ab   = op_a & op_b;

    alu_adder #(.W(W)) u_add (
        .a(op_a), .b(op_b), .invert_b(sub_mode), .cin(add_cin),
        .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
    );

    alu_logic #(.W(W)) u_log (
        .op(op), .a(op_a), .b(op_b), .res(logic_res)
    );

    alu_unary #(.W(W)) u_una (
        .op(op), .opd(op_b), .cin(cur.c), .res(un_res), .shout(un_shout)
    );

    // Purpose: choose the visible result for each operation class
    always_comb begin
        unique case (op)
            OP_OR, OP_AND, OP_XOR, OP_PASS, OP_TSET, OP_TCLR: result = logic_res;
            OP_ADD, OP_SUB:                                   result = add_sum;
            OP_CMP, OP_BTST, OP_BTSTI:                        result = op_a;
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR, OP_INC, OP_DEC: result = un_res;
            OP_SLOAD:                                         result = op_b;
            default:                                          result = '0;
        endcase
    end

    // Purpose: new flag values and the subset each operation owns
    always_comb begin
        fl_val  = '0;
        fl_mask = '0;
        unique case (op)
            OP_OR, OP_AND, OP_XOR, OP_PASS, OP_INC, OP_DEC: begin
                fl_val.n  = result[W-1];
                fl_val.z  = (result == '0);
                fl_mask.n = 1'b1;
                fl_mask.z = 1'b1;
            end
            OP_ADD, OP_SUB: begin
                fl_val.n = add_sum[W-1];
                fl_val.v = add_ovf;
                fl_val.z = (add_sum == '0);
                fl_val.c = add_cout;
                fl_mask  = status_t'(8'hC3);
            end
            OP_CMP: begin
                fl_val.n = add_sum[W-1];
                fl_val.z = (add_sum == '0);
                fl_val.c = add_cout;
                fl_mask  = status_t'(8'h83);
            end
            OP_BTST: begin
                fl_val.n = op_b[W-1];
                fl_val.v = op_b[W-2];
                fl_val.z = (and_ab == '0);
                fl_mask  = status_t'(8'hC2);
            end
            OP_BTSTI, OP_TSET, OP_TCLR: begin
                fl_val.z  = (and_ab == '0);
                fl_mask.z = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                fl_val.n = un_res[W-1];
                fl_val.z = (un_res == '0);
                fl_val.c = un_shout;
                fl_mask  = status_t'(8'h83);
            end
            OP_SLOAD: begin
                fl_val  = status_t'(op_b[7:0]);
                fl_mask = status_t'(8'hFF);
            end
            default: begin
                fl_val  = '0;
                fl_mask = '0;
            end
        endcase
    end

    alu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
        .new_val(fl_val), .upd_mask(fl_mask), .stat_q(status)
    );

endmodule

// File: rtl/alu_status_chk.sv
// Checker for alu_status_unit: temporal rules on the status byte and the
// add result, seen only at the ports. Attached by bind below.
module alu_status_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   op_sel,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         upd_en,
    input logic [W-1:0] result,
    input logic [7:0]   status
);
    import alu_pkg::*;

    // R1
    one_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_ONE]);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(status));

    // R4
    add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADD) |-> (result == W'(op_a + op_b + {{(W-1){1'b0}}, status[BIT_C]})));

    // R6
    cmp_keeps_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == OP_CMP) |=> (status[BIT_V] == $past(status[BIT_V])));

    // R7
    btst_copies_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == OP_BTST) |=>
        (status[BIT_N] == $past(op_b[W-1]) && status[BIT_V] == $past(op_b[W-2])));

    // R9
    step_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_sel == OP_INC || op_sel == OP_DEC)) |=>
        (status[BIT_C] == $past(status[BIT_C]) && status[BIT_V] == $past(status[BIT_V])));

    // R13
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > OP_LAST) |-> (result == '0) ##1 $stable(status));

endmodule

bind alu_status_unit alu_status_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;
    import alu_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_sel = 5'd0;
    logic [7:0] op_a = 8'h00, op_b = 8'h00;
    logic       upd_en = 1'b0;
    logic [7:0] result, status;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
        .upd_en(upd_en), .result(result), .status(status)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Independent model: returns {result, next status} from the requirements
    function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [7:0] s);
        logic [7:0] r, ns, t1, t2;
        int t;
        r = 8'h00; ns = s;
        case (op)
            5'd0:  r = a | b;
            5'd1:  r = a & b;
            5'd2:  r = a ^ b;
            5'd3:  r = b;
            5'd4: begin
                t = int'(a) + int'(b) + int'(s[0]); r = t[7:0];
                t1 = ~(a ^ b) & (a ^ r); ns[6] = t1[7]; ns[0] = (t > 255);
            end
            5'd5: begin
                t = int'(a) - int'(b) - (s[0] ? 0 : 1); r = t[7:0];
                t2 = (a ^ b) & (a ^ r); ns[6] = t2[7]; ns[0] = (t >= 0);
            end
            5'd6: begin
                t = int'(a) - int'(b); t1 = t[7:0];
                ns[7] = t1[7]; ns[1] = (a == b); ns[0] = (a >= b); r = a;
            end
            5'd7:  begin r = a; ns[7] = b[7]; ns[6] = b[6]; ns[1] = ((a & b) == 0); end
            5'd8:  begin r = a; ns[1] = ((a & b) == 0); end
            5'd9:  begin r = b << 1; ns[0] = b[7]; end
            5'd10: begin r = b >> 1; ns[0] = b[0]; end
            5'd11: begin r = (b << 1) | {7'd0, s[0]}; ns[0] = b[7]; end
            5'd12: begin r = (b >> 1) | {s[0], 7'd0}; ns[0] = b[0]; end
            5'd13: r = b + 8'd1;
            5'd14: r = b - 8'd1;
            5'd15: begin r = b | a;  ns[1] = ((a & b) == 0); end
            5'd16: begin r = b & ~a; ns[1] = ((a & b) == 0); end
            5'd17: begin r = b; ns = b | 8'h20; end
            default: begin r = 8'h00; ns = s; end
        endcase
        // N/Z from the result for the classes that own them
        if (op <= 5'd5 || (op >= 5'd9 && op <= 5'd14)) begin
            ns[7] = r[7]; ns[1] = (r == 8'h00);
        end
        return {r, ns};
    endfunction

    // One vector: preload status, apply the operation, check result and status
    task automatic run(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] pre, input logic upd, input string tag);
        logic [15:0] e;
        logic [7:0]  ps;
        ps = pre | 8'h20;
        @(negedge clk); op_sel = 5'd17; op_b = pre; upd_en = 1'b1;
        @(negedge clk);
        e = model(op, a, b, ps);
        op_sel = op; op_a = a; op_b = b; upd_en = upd;
        #1 check(result, e[15:8], {tag, " result"});
        @(posedge clk); #1;
        check(status, upd ? e[7:0] : ps, {tag, " status"});
    endtask

    function automatic logic [7:0] pat(input int a, input int b);
        logic [7:0] x, y;
        x = 8'(a); y = 8'(b);
        return x ^ {y[6:0], y[7]} ^ 8'h96;
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !done) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [7:0] p;
        repeat (3) @(posedge clk);
        #1 check(status, 8'h20, "R1 reset value");
        @(negedge clk); rst_n = 1'b1;

        // R3 logic and pass-through
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 6; bi++)
                    run(5'(op), 8'(a), 8'(bi * 51), pat(a, bi * 51), 1'b1, "R3 logic");

        // R4 add, R5 subtract; pattern varies D so R12 is covered
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++)
                for (int bi = 0; bi < 16; bi++) begin
                    p = pat(a, bi * 17); p[0] = c[0];
                    run(5'd4, 8'(a), 8'(bi * 17), p, 1'b1, p[3] ? "R12 add D=1" : "R4 add");
                    run(5'd5, 8'(a), 8'(bi * 17), p, 1'b1, p[3] ? "R12 sub D=1" : "R5 sub");
                end

        // R6 compare, V preset both ways
        for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 16; bi++)
                run(5'd6, 8'(a), 8'(bi * 17), pat(a, bi * 17), 1'b1, "R6 compare");

        // R7 bit tests
        for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 16; bi++) begin
                run(5'd7, 8'(a), 8'(bi * 17), pat(a, bi), 1'b1, "R7 bit test");
                run(5'd8, 8'(a), 8'(bi * 17), pat(bi, a), 1'b1, "R7 bit test imm");
            end

        // R8 shifts and rotates, R9 increment/decrement, both carry values
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 256; b++) begin
                p = pat(b, 3 * b); p[0] = c[0];
                for (int op = 9; op < 13; op++)
                    run(5'(op), 8'h5A, 8'(b), p, 1'b1, "R8 shift/rotate");
                run(5'd13, 8'h00, 8'(b), p | 8'h41, 1'b1, "R9 increment");
                run(5'd14, 8'h00, 8'(b), p | 8'h41, 1'b1, "R9 decrement");
            end

        // R10 test-and-set / test-and-reset
        for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 6; bi++) begin
                run(5'd15, 8'(a), 8'(bi * 51), pat(a, bi), 1'b1, "R10 test-set");
                run(5'd16, 8'(a), 8'(bi * 51), pat(bi, a), 1'b1, "R10 test-reset");
            end

        // R11 status load, every byte
        for (int b = 0; b < 256; b++)
            run(5'd17, 8'h00, 8'(b), 8'(~b), 1'b1, "R11 status load");

        // R2 no update without enable
        for (int a = 0; a < 256; a++)
            run(5'(a % 18), 8'(a), 8'(255 - a), pat(a, 7), 1'b0, "R2 hold");

        // R13 unassigned codes
        for (int op = 18; op < 32; op++) begin
            run(5'(op), 8'hFF, 8'h00, 8'h00, 1'b1, "R13 unused code");
            run(5'(op), 8'h81, 8'h7E, 8'hFF, 1'b1, "R13 unused code");
        end

        // R1 synchronous reset beats an enabled update
        @(negedge clk); op_sel = 5'd17; op_b = 8'hFF; upd_en = 1'b1;
        @(negedge clk); rst_n = 1'b0; op_sel = 5'd4;
        @(posedge clk); #1 check(status, 8'h20, "R1 reset over update");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule